// File: doc/BRIEF.md
# Dual-Channel Event Timestamp Latch

This block records the value of a free-running 64-bit time counter at the moment an external event input rises. It has two channels, each with its own event pin, its own stored timestamp and its own status flag. An event pin is either taken through a two-flop synchronizer, for signals from another clock domain, or sampled with a single register, for signals already timed to this clock. The path is chosen per channel.

Each channel is a two-state machine. In `SLOT_ARMED` the channel holds no unread timestamp. The transition *capture* (a rising edge) moves it to `SLOT_HELD`, stores the time and raises its status flag. In `SLOT_HELD` the transition *overwrite* (a rising edge with hold mode off) stores a newer time and stays in `SLOT_HELD`. In hold mode the edge is dropped. The transition *acknowledge* (software writes 1 to the status bit) returns the channel to `SLOT_ARMED`. With hold mode on, the first event after an acknowledge is kept until the next acknowledge.

Software reaches the block through a small word-addressed register port. Reading a channel's low timestamp word copies that channel's high word into a shadow register. A later read of the high word returns the shadow, so the two halves always come from the same capture.

Top module: `ts_capture_unit`

## Requirements
- R1: After reset, every address (0 to 7) reads 0, both channels are in `SLOT_ARMED` and `bus_rdata` is 0.
- R2: Address 0 is the config word. Bit 6+c is hold mode for channel c and bit 16+c selects the synchronized path for channel c. All other bits ignore writes and read 0.
- R3: With the synchronized path off, an event pin that is low at clock edge n-1 and high at edge n stores the time_now value present at edge n+1, and the status bit is set after edge n+1.
- R4: With the synchronized path on, the same edge stores the time_now value present at edge n+3.
- R5: Address 1 is status, with bit c set while channel c is in `SLOT_HELD`. Writing 1 to bit c clears it and writing 0 has no effect.
- R6: In hold mode, rising edges seen while the status bit is set leave the stored timestamp unchanged. After an acknowledge, the next edge is captured again.
- R7: With hold mode off, every rising edge replaces the stored timestamp and the status bit stays set.
- R8: When an acknowledge and an edge are seen at the same clock edge, a channel in hold mode drops the edge and returns to `SLOT_ARMED`. Without hold mode it stores the new time and stays in `SLOT_HELD`.
- R9: Address 2+2c reads bits 31:0 of channel c's timestamp and copies bits 63:32 into that channel's shadow. Address 3+2c returns the shadow, which is 0 after reset. Captures do not change the shadow.
- R10: bus_rdata changes only at the clock edge after a cycle with bus_rd high. Addresses 6 and 7 read 0.
- R11: Only 0-to-1 transitions are events. A level held high and a falling edge capture nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | 64 | Running time counter to be latched |
| ev_in | input | 2 | Event pins, bit c drives channel c |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |

## Verification
The hardest case to reach from the ports is the acknowledge-versus-edge collision of R8. The status write must land on exactly the clock edge at which the channel's edge detector fires, and that edge comes one cycle after the pin rises on the direct path. The bench raises the pin on one falling clock edge, puts the status write on the bus at the next falling edge, and does this once with hold mode on and once with it off. Exact capture latencies are checked by driving time_now as an affine function of a cycle counter. Each stored value then shows which clock edge latched it.

// File: rtl/tscap_pkg.sv
package tscap_pkg;

    typedef enum logic {
        SLOT_ARMED = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_t;

    localparam int unsigned REG_CFG     = 0;
    localparam int unsigned REG_STATUS  = 1;
    localparam int unsigned REG_TS_BASE = 2;

endpackage

// File: rtl/tscap_edge_detect.sv
module tscap_edge_detect #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic use_sync,
    output logic rise
);
    logic [SYNC_STAGES:0] pipe_q;
    logic                 sel;
    logic                 prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q[0] <= 1'b0;
        end else begin
            pipe_q[0] <= pin;
        end
    end

    for (genvar s = 1; s <= SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q[s] <= 1'b0;
            end else begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    // direct path uses the first sampling register, synced path the last
    assign sel = use_sync ? pipe_q[SYNC_STAGES] : pipe_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sel;
        end
    end

    assign rise = sel & ~prev_q;

    // R11: an event lasts exactly one cycle
    p_rise_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/tscap_slot.sv
module tscap_slot
    import tscap_pkg::*;
#(
    parameter int unsigned TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rise,
    input  logic            hold_first,
    input  logic            clr_req,
    input  logic [TS_W-1:0] time_now,
    output logic            held,
    output logic [TS_W-1:0] stamp
);
    slot_state_t state_q;
    slot_state_t state_nxt;
    logic        take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_ARMED;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state_q;
        take      = 1'b0;
        unique case (state_q)
            SLOT_ARMED: begin
                if (rise) begin
                    state_nxt = SLOT_HELD;
                    take      = 1'b1;
                end
            end
            SLOT_HELD: begin
                if (rise && !hold_first) begin
                    take = 1'b1;
                end else if (clr_req) begin
                    state_nxt = SLOT_ARMED;
                end
            end
            default: begin
                state_nxt = SLOT_ARMED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stamp <= '0;
        end else if (take) begin
            stamp <= time_now;
        end
    end

    assign held = (state_q == SLOT_HELD);

    // R3: an edge in the armed state captures the current time
    p_arm_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_ARMED && rise) |=> (held && stamp == $past(time_now)));

    // R6: hold mode freezes a held timestamp
    p_hold_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_HELD && hold_first) |=> (stamp == $past(stamp)));

    // R7: without hold mode a held channel is overwritten and stays held
    p_overwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_HELD && rise && !hold_first) |=> (held && stamp == $past(time_now)));

    // R5 / R8: acknowledge re-arms unless an accepted edge arrives together
    p_clear_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_HELD && clr_req && (hold_first || !rise)) |=> !held);

endmodule

// File: rtl/tscap_regs.sv
module tscap_regs
    import tscap_pkg::*;
#(
    parameter int unsigned N_CH      = 2,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 3,
    parameter int unsigned HOLD_LSB  = 6,
    parameter int unsigned ASYNC_LSB = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_wr,
    input  logic                             bus_rd,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    input  logic [N_CH-1:0]                  held,
    input  logic [N_CH-1:0][2*DATA_W-1:0]    stamps,
    output logic [N_CH-1:0]                  hold_en,
    output logic [N_CH-1:0]                  async_en,
    output logic [N_CH-1:0]                  clr_req,
    output logic [DATA_W-1:0]                bus_rdata
);
    localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(REG_CFG);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
    localparam logic [DATA_W-1:0] CFG_MASK =
        (((DATA_W'(1) << N_CH) - DATA_W'(1)) << HOLD_LSB) |
        (((DATA_W'(1) << N_CH) - DATA_W'(1)) << ASYNC_LSB);

    logic [N_CH-1:0]   hold_q;
    logic [N_CH-1:0]   async_q;
    logic [DATA_W-1:0] shadow_q [N_CH];
    logic [DATA_W-1:0] rd_mux;
    logic              wdata_unused;

    assign wdata_unused = ^bus_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            async_q <= '0;
        end else if (bus_wr && bus_addr == A_CFG) begin
            hold_q  <= bus_wdata[HOLD_LSB +: N_CH];
            async_q <= bus_wdata[ASYNC_LSB +: N_CH];
        end
    end

    assign hold_en  = hold_q;
    assign async_en = async_q;
    assign clr_req  = (bus_wr && bus_addr == A_STATUS) ? bus_wdata[N_CH-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < N_CH; c++) begin
                shadow_q[c] <= '0;
            end
        end else if (bus_rd) begin
            for (int c = 0; c < N_CH; c++) begin
                if (bus_addr == ADDR_W'(REG_TS_BASE + 2 * c)) begin
                    shadow_q[c] <= stamps[c][2*DATA_W-1:DATA_W];
                end
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == A_CFG) begin
            rd_mux[HOLD_LSB +: N_CH]  = hold_q;
            rd_mux[ASYNC_LSB +: N_CH] = async_q;
        end else if (bus_addr == A_STATUS) begin
            rd_mux[N_CH-1:0] = held;
        end
        for (int c = 0; c < N_CH; c++) begin
            if (bus_addr == ADDR_W'(REG_TS_BASE + 2 * c)) begin
                rd_mux = stamps[c][DATA_W-1:0];
            end
            if (bus_addr == ADDR_W'(REG_TS_BASE + 2 * c + 1)) begin
                rd_mux = shadow_q[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    // R10: read data only moves after a read strobe
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R2: unused config bits always read back as zero
    p_cfg_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_CFG) |=> ((bus_rdata & ~CFG_MASK) == '0));

endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit #(
    parameter int unsigned N_CH        = 2,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HOLD_LSB    = 6,
    parameter int unsigned ASYNC_LSB   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*DATA_W-1:0]  time_now,
    input  logic [N_CH-1:0]      ev_in,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata
);
    localparam int unsigned TS_W = 2 * DATA_W;

    logic [N_CH-1:0]           hold_en;
    logic [N_CH-1:0]           async_en;
    logic [N_CH-1:0]           clr_req;
    logic [N_CH-1:0]           rise;
    logic [N_CH-1:0]           held;
    logic [N_CH-1:0][TS_W-1:0] stamps;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        tscap_edge_detect #(
            .SYNC_STAGES(SYNC_STAGES)
        ) i_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (ev_in[c]),
            .use_sync(async_en[c]),
            .rise    (rise[c])
        );

        tscap_slot #(
            .TS_W(TS_W)
        ) i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .rise      (rise[c]),
            .hold_first(hold_en[c]),
            .clr_req   (clr_req[c]),
            .time_now  (time_now),
            .held      (held[c]),
            .stamp     (stamps[c])
        );
    end

    tscap_regs #(
        .N_CH     (N_CH),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .HOLD_LSB (HOLD_LSB),
        .ASYNC_LSB(ASYNC_LSB)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .held     (held),
        .stamps   (stamps),
        .hold_en  (hold_en),
        .async_en (async_en),
        .clr_req  (clr_req),
        .bus_rdata(bus_rdata)
    );

endmodule

// File: tb/test_ts_capture_unit.sv
module test_ts_capture_unit;
    localparam int NCH = 2;
    localparam logic [63:0] T_BASE = 64'h0000_0002_FFFF_FF00;
    localparam logic [63:0] T_STEP = 64'h0000_0000_4000_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cyc = '0;
    logic [63:0] time_now;
    logic [1:0]  ev_in = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 64'd1;
    assign time_now = T_BASE + T_STEP * cyc;

    ts_capture_unit i_ts_capture_unit (
        .clk(clk), .rst_n(rst_n), .time_now(time_now), .ev_in(ev_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_rdata;
    logic [63:0] m_ts     [NCH];
    logic [31:0] m_shadow [NCH];
    bit          m_held   [NCH];
    bit          m_hold   [NCH];
    bit          m_async  [NCH];
    bit [2:0]    m_hist   [NCH];
    bit          m_prev   [NCH];
    bit          m_sel, m_rise, m_clr;

    function automatic logic [31:0] m_read(logic [2:0] a);
        logic [31:0] v = '0;
        case (a)
            3'd0: begin
                v[6] = m_hold[0];  v[7] = m_hold[1];
                v[16] = m_async[0]; v[17] = m_async[1];
            end
            3'd1: begin v[0] = m_held[0]; v[1] = m_held[1]; end
            3'd2: v = m_ts[0][31:0];
            3'd3: v = m_shadow[0];
            3'd4: v = m_ts[1][31:0];
            3'd5: v = m_shadow[1];
            default: v = '0;
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rdata = '0;
            for (int c = 0; c < NCH; c++) begin
                m_ts[c] = '0; m_shadow[c] = '0; m_held[c] = 0;
                m_hold[c] = 0; m_async[c] = 0; m_hist[c] = '0; m_prev[c] = 0;
            end
        end else begin
            if (bus_rd) begin
                m_rdata = m_read(bus_addr);
                for (int c = 0; c < NCH; c++)
                    if (int'(bus_addr) == 2 + 2 * c) m_shadow[c] = m_ts[c][63:32];
            end
            for (int c = 0; c < NCH; c++) begin
                m_sel = m_async[c] ? m_hist[c][2] : m_hist[c][0];
                m_rise = m_sel && !m_prev[c];
                m_prev[c] = m_sel;
                m_clr = bus_wr && bus_addr == 3'd1 && bus_wdata[c];
                if (!m_held[c]) begin
                    if (m_rise) begin m_ts[c] = time_now; m_held[c] = 1; end
                end else if (m_rise && !m_hold[c]) begin
                    m_ts[c] = time_now;
                end else if (m_clr) begin
                    m_held[c] = 0;
                end
                m_hist[c] = {m_hist[c][1:0], ev_in[c]};
            end
            if (bus_wr && bus_addr == 3'd0) begin
                for (int c = 0; c < NCH; c++) begin
                    m_hold[c]  = bus_wdata[6 + c];
                    m_async[c] = bus_wdata[16 + c];
                end
            end
        end
    end

    // R10: read data compared against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_tests++;
            if (bus_rdata !== m_rdata) begin
                n_fail++;
                $display("FAIL R10 per-clock read data: actual %h expected %h", bus_rdata, m_rdata);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    function automatic logic [63:0] t_at(logic [63:0] edge_idx);
        return T_BASE + T_STEP * edge_idx;
    endfunction

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [63:0] j, t1, t2, t_hold;
        @(negedge clk);
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1: reset state of every address
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reset read", v, 32'h0);
        end

        // R2: config field positions and reserved bits
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); chk("R2 config readback", v, 32'h0003_00C0);
        wr(3'd0, 32'h0);
        rd(3'd0, v); chk("R2 config cleared", v, 32'h0);

        // R3: direct path capture latency
        ev_in[0] = 1'b1; j = cyc;
        tick(3);
        rd(3'd1, v); chk("R5 status set ch0", v, 32'h1);
        rd(3'd2, v); chk("R3 direct capture low", v, t_at(j + 1)[31:0]);
        rd(3'd3, v); chk("R9 high after low read", v, t_at(j + 1)[63:32]);

        // R11: steady high level, then falling edge
        tick(5);
        rd(3'd2, v); chk("R11 level high no recapture", v, t_at(j + 1)[31:0]);
        wr(3'd1, 32'h0);
        rd(3'd1, v); chk("R5 write zero ignored", v, 32'h1);
        wr(3'd1, 32'h1);
        rd(3'd1, v); chk("R5 write one clears", v, 32'h0);
        ev_in[0] = 1'b0;
        tick(5);
        rd(3'd1, v); chk("R11 falling edge ignored", v, 32'h0);

        // R4: synchronized path latency
        wr(3'd0, 32'h0001_0000);
        ev_in[0] = 1'b1; j = cyc;
        tick(6);
        ev_in[0] = 1'b0;
        t1 = t_at(j + 3);
        rd(3'd2, v); chk("R4 synced capture low", v, t1[31:0]);
        tick(4);

        // R7 and R9: overwrite without hold, shadow stays on older capture
        ev_in[0] = 1'b1; j = cyc;
        tick(6);
        ev_in[0] = 1'b0;
        t2 = t_at(j + 3);
        rd(3'd3, v); chk("R9 shadow unaffected by capture", v, t1[63:32]);
        rd(3'd1, v); chk("R7 status still set", v, 32'h1);
        rd(3'd2, v); chk("R7 overwrite low", v, t2[31:0]);
        rd(3'd3, v); chk("R9 shadow from new low read", v, t2[63:32]);
        tick(4);

        // R6: hold mode on channel 1, direct path
        wr(3'd0, 32'h0000_0080);
        ev_in[1] = 1'b1; j = cyc;
        tick(3);
        ev_in[1] = 1'b0;
        t_hold = t_at(j + 1);
        tick(2);
        rd(3'd4, v); chk("R6 first event captured", v, t_hold[31:0]);
        rd(3'd5, v); chk("R9 ch1 high", v, t_hold[63:32]);
        ev_in[1] = 1'b1;
        tick(3);
        ev_in[1] = 1'b0;
        tick(2);
        rd(3'd4, v); chk("R6 later edge ignored", v, t_hold[31:0]);
        rd(3'd1, v); chk("R5 status both set", v, 32'h3);
        wr(3'd1, 32'h2);
        rd(3'd1, v); chk("R5 ch1 cleared only", v, 32'h1);
        ev_in[1] = 1'b1; j = cyc;
        tick(3);
        ev_in[1] = 1'b0;
        t_hold = t_at(j + 1);
        tick(2);
        rd(3'd4, v); chk("R6 re-armed capture", v, t_hold[31:0]);

        // R8: acknowledge together with edge, hold mode
        ev_in[1] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 32'h2;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        tick(2);
        ev_in[1] = 1'b0;
        rd(3'd1, v); chk("R8 hold: clear wins", v, 32'h1);
        rd(3'd4, v); chk("R8 hold: edge dropped", v, t_hold[31:0]);

        // R8: acknowledge together with edge, no hold, direct path
        wr(3'd0, 32'h0);
        tick(4);
        ev_in[0] = 1'b1; j = cyc;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        tick(2);
        ev_in[0] = 1'b0;
        rd(3'd1, v); chk("R8 no hold: stays held", v, 32'h1);
        rd(3'd2, v); chk("R8 no hold: new stamp", v, t_at(j + 1)[31:0]);

        // R10: unmapped addresses
        rd(3'd6, v); chk("R10 unmapped addr 6", v, 32'h0);
        rd(3'd7, v); chk("R10 unmapped addr 7", v, 32'h0);

        tick(3);
        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end

endmodule